// File: doc/BRIEF.md
# Sparse Pixel-Hit Frame Deserializer

This block sits behind one detector readout group. It watches a single serial line that carries one bit per clock, picks out hit records and stores each record's photon count in the slot of the pixel it addresses. A record is a 3-bit start marker, then a 5-bit count, then an 8-bit pixel address. The records are collected into a 256-slot frame, one slot per pixel of the group.

A `frame_sync` pulse closes the frame. The block then streams the whole frame to the downstream correlators as an indexed write stream. Every pixel address from 0 to 255 comes out once, in ascending order. A pixel that received no record in that frame is sent as count zero. The last beat of the stream is marked with `frame_done`. Two storage banks alternate, so the records of the next frame can arrive while the previous frame is still streaming out.

The block works with either readout mode of the group, chosen by `img_mode`. In sparse mode only pixels that saw photons send records, and more than 62 records in one frame is flagged. In imaging mode every pixel sends a record in address order, and a record whose address is not the expected next index is flagged.

Top module: `frame_deser`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `frame_done`, `hit_overflow` and `seq_error` are 0 until records or a frame sync arrive.
- R2: A record is recognised only after the three consecutive line bits 1,0,1. The next 5 bits are the count and the 8 bits after them are the pixel address, both sent MSB first. Line bits that do not form this marker are ignored.
- R3: After a record's 13 field bits, marker search starts afresh. Bits inside a record's fields never begin a new record, even when they contain the pattern 1,0,1.
- R4: One cycle after an accepted `frame_sync`, the block emits 256 beats in consecutive cycles with `out_addr` 0,1,...,255. Each beat's `out_count` is the count of the last record for that address in the closed frame, or 0 if that address had no record.
- R5: `frame_done` is high for exactly one cycle, on the beat with address 255.
- R6: When an address appears more than once in a frame, the count of the later record is the one output.
- R7: Records completed after a `frame_sync` belong to the next frame, even while the previous frame is still streaming. No count carries over from one frame into a later one.
- R8: In sparse mode (`img_mode`=0), `hit_overflow` rises when the 63rd record of a frame completes and stays high until the next accepted `frame_sync` clears it. The overflowing records are still stored.
- R9: In imaging mode (`img_mode`=1), the k-th record of a frame (counting from 0) is expected to carry address k. A mismatch sets `seq_error`, which stays high until the next accepted `frame_sync`. A fully ordered frame leaves it at 0.
- R10: In imaging mode `hit_overflow` is never raised, even for 256 records in one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial record stream of the readout group |
| img_mode | input | 1 | 0 = sparse readout, 1 = imaging readout |
| frame_sync | input | 1 | One-cycle pulse that closes the current frame |
| out_valid | output | 1 | Output beat valid |
| out_addr | output | 8 | Pixel address of the output beat |
| out_count | output | 5 | Photon count of the output beat |
| frame_done | output | 1 | High on the last beat of a frame |
| hit_overflow | output | 1 | Sticky: sparse frame held more than 62 records |
| seq_error | output | 1 | Sticky: imaging record address out of sequence |

## Verification
The hardest situation to reach is a record whose field bits contain the start pattern, combined with idle gaps that nearly form it. Both can make a faulty hunter resynchronise mid-record. The stimulus uses random counts and addresses, which regularly contain 1,0,1. It separates records with runs of ones followed by at least two zeros, and it adds a directed record whose count and address are built around the pattern. A second hard case is the overlap of a draining frame with incoming records. Each new frame's records are sent immediately after the sync, so they land while the 256-beat stream of the previous frame is still running.

// File: rtl/frame_deser_pkg.sv
package frame_deser_pkg;
  localparam int CNT_W_DEF   = 5;
  localparam int ADDR_W_DEF  = 8;
  localparam int MARK_W_DEF  = 3;
  localparam logic [MARK_W_DEF-1:0] MARK_DEF = 3'b101;
  localparam int MAX_HITS_DEF = 62;

  typedef enum logic {
    RX_HUNT  = 1'b0,
    RX_FIELD = 1'b1
  } rx_state_e;
endpackage

// File: rtl/fd_hit_rx.sv
module fd_hit_rx
  import frame_deser_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int MARK_W = MARK_W_DEF,
  parameter logic [MARK_W-1:0] MARK = MARK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic              rec_valid,
  output logic [CNT_W-1:0]  rec_cnt,
  output logic [ADDR_W-1:0] rec_addr
);
  localparam int FLD_W = CNT_W + ADDR_W;
  localparam int BC_W  = $clog2(FLD_W);

  rx_state_e          state_q, state_d;
  logic [MARK_W-1:0]  mark_q, mark_d, mark_win;
  logic [FLD_W-1:0]   fld_q, fld_d;
  logic [BC_W-1:0]    bcnt_q, bcnt_d;
  logic               rv_d;

  assign mark_win = {mark_q[MARK_W-2:0], ser_in};

  always_comb begin
    state_d = state_q;
    mark_d  = mark_q;
    fld_d   = fld_q;
    bcnt_d  = bcnt_q;
    rv_d    = 1'b0;
    case (state_q)
      RX_HUNT: begin
        mark_d = mark_win;
        if (mark_win == MARK) begin
          state_d = RX_FIELD;
          bcnt_d  = '0;
          mark_d  = '0;
        end
      end
      RX_FIELD: begin
        fld_d  = {fld_q[FLD_W-2:0], ser_in};
        bcnt_d = bcnt_q + 1'b1;
        if (bcnt_q == BC_W'(FLD_W - 1)) begin
          state_d = RX_HUNT;
          rv_d    = 1'b1;
          mark_d  = '0;
        end
      end
      default: state_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_HUNT;
      mark_q    <= '0;
      fld_q     <= '0;
      bcnt_q    <= '0;
      rec_valid <= 1'b0;
      rec_cnt   <= '0;
      rec_addr  <= '0;
    end else begin
      state_q   <= state_d;
      mark_q    <= mark_d;
      fld_q     <= fld_d;
      bcnt_q    <= bcnt_d;
      rec_valid <= rv_d;
      if (rv_d) begin
        rec_cnt  <= fld_d[FLD_W-1 -: CNT_W];
        rec_addr <= fld_d[ADDR_W-1:0];
      end
    end
  end

  // R3: a record needs at least marker + fields bits, so pulses never touch
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);
  // R2: while collecting fields, the marker window stays cleared
  a_r2_field_no_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_FIELD) |-> (mark_q == '0));
endmodule

// File: rtl/fd_seq_check.sv
module fd_seq_check
  import frame_deser_pkg::*;
#(
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int MAX_HITS = MAX_HITS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_take,
  input  logic              img_mode,
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_addr,
  output logic              hit_overflow,
  output logic              seq_error
);
  localparam int HC_W = $clog2(MAX_HITS + 2);
  localparam logic [HC_W-1:0] HIT_LIM = HC_W'(MAX_HITS);
  localparam logic [HC_W-1:0] HIT_SAT = HC_W'(MAX_HITS + 1);

  logic [HC_W-1:0]   hits_q, hits_d;
  logic [ADDR_W-1:0] exp_q, exp_d;
  logic              ovf_d, err_d;

  always_comb begin
    hits_d = hits_q;
    exp_d  = exp_q;
    ovf_d  = hit_overflow;
    err_d  = seq_error;
    if (frame_take) begin
      hits_d = '0;
      exp_d  = '0;
      ovf_d  = 1'b0;
      err_d  = 1'b0;
    end else if (rec_valid) begin
      if (hits_q != HIT_SAT) hits_d = hits_q + 1'b1;
      if (!img_mode && hits_q >= HIT_LIM) ovf_d = 1'b1;
      if (img_mode && rec_addr != exp_q) err_d = 1'b1;
      exp_d = exp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q       <= '0;
      exp_q        <= '0;
      hit_overflow <= 1'b0;
      seq_error    <= 1'b0;
    end else begin
      hits_q       <= hits_d;
      exp_q        <= exp_d;
      hit_overflow <= ovf_d;
      seq_error    <= err_d;
    end
  end

  a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_overflow && !frame_take) |=> hit_overflow);
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_error && !frame_take) |=> seq_error);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_take |=> (!hit_overflow && !seq_error));
  a_r10_img_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (img_mode && !hit_overflow) |=> !hit_overflow);
endmodule

// File: rtl/fd_frame_buf.sv
module fd_frame_buf
  import frame_deser_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              rec_valid,
  input  logic [CNT_W-1:0]  rec_cnt,
  input  logic [ADDR_W-1:0] rec_addr,
  output logic              frame_take,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CNT_W-1:0]  out_count,
  output logic              frame_done
);
  localparam int NPIX = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [CNT_W-1:0]        cnt_mem [2][NPIX];
  logic [1:0][NPIX-1:0]    vld_q, vld_d;
  logic                    act_q, act_d;
  logic                    drain_q, drain_d;
  logic [ADDR_W-1:0]       dptr_q, dptr_d;
  logic                    rd_bank;
  logic                    ov_d, done_d;
  logic [CNT_W-1:0]        oc_d;

  assign frame_take = frame_sync && !drain_q;
  assign rd_bank    = ~act_q;

  // bank swap and drain pointer
  always_comb begin
    act_d   = act_q;
    drain_d = drain_q;
    dptr_d  = dptr_q;
    if (frame_take) begin
      act_d   = ~act_q;
      drain_d = 1'b1;
      dptr_d  = '0;
    end else if (drain_q) begin
      dptr_d = dptr_q + 1'b1;
      if (dptr_q == LAST) drain_d = 1'b0;
    end
  end

  // written-slot flags: set by records, cleared as the drain passes
  always_comb begin
    vld_d = vld_q;
    if (rec_valid) vld_d[act_q][rec_addr] = 1'b1;
    if (drain_q)   vld_d[rd_bank][dptr_q] = 1'b0;
  end

  always_comb begin
    ov_d   = drain_q;
    done_d = drain_q && (dptr_q == LAST);
    oc_d   = vld_q[rd_bank][dptr_q] ? cnt_mem[rd_bank][dptr_q] : '0;
  end

  always_ff @(posedge clk) begin
    if (rec_valid) cnt_mem[act_q][rec_addr] <= rec_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      drain_q    <= 1'b0;
      dptr_q     <= '0;
      vld_q      <= '0;
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_count  <= '0;
      frame_done <= 1'b0;
    end else begin
      act_q      <= act_d;
      drain_q    <= drain_d;
      dptr_q     <= dptr_d;
      vld_q      <= vld_d;
      out_valid  <= ov_d;
      frame_done <= done_d;
      if (ov_d) begin
        out_addr  <= dptr_q;
        out_count <= oc_d;
      end
    end
  end

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_addr != LAST) |=> (out_valid && out_addr == $past(out_addr) + 1'b1));
  a_r4_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid)) |-> (out_addr == '0));
  a_r5_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (out_valid && out_addr == LAST));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import frame_deser_pkg::*;
#(
  parameter int CNT_W    = CNT_W_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int MAX_HITS = MAX_HITS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              img_mode,
  input  logic              frame_sync,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CNT_W-1:0]  out_count,
  output logic              frame_done,
  output logic              hit_overflow,
  output logic              seq_error
);
  logic              rec_valid;
  logic [CNT_W-1:0]  rec_cnt;
  logic [ADDR_W-1:0] rec_addr;
  logic              frame_take;

  fd_hit_rx #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MARK_W(MARK_W_DEF), .MARK(MARK_DEF)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .rec_valid(rec_valid), .rec_cnt(rec_cnt), .rec_addr(rec_addr)
  );

  fd_frame_buf #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .rec_valid(rec_valid), .rec_cnt(rec_cnt), .rec_addr(rec_addr),
    .frame_take(frame_take), .out_valid(out_valid), .out_addr(out_addr),
    .out_count(out_count), .frame_done(frame_done)
  );

  fd_seq_check #(.ADDR_W(ADDR_W), .MAX_HITS(MAX_HITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_take(frame_take), .img_mode(img_mode),
    .rec_valid(rec_valid), .rec_addr(rec_addr),
    .hit_overflow(hit_overflow), .seq_error(seq_error)
  );
endmodule

// File: tb/frame_deser_test.sv
module frame_deser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       img_mode = 1'b0;
  logic       frame_sync = 1'b0;
  logic       out_valid, frame_done, hit_overflow, seq_error;
  logic [7:0] out_addr;
  logic [4:0] out_count;

  int n_chk = 0, n_bad = 0;
  int exp_cur [256];
  int exp_prev [256];
  int beat_idx = 0, frame_bad = 0;
  bit pending = 1'b0, finished = 1'b0;
  string cur_tag = "R4";

  always #5 clk = ~clk;

  frame_deser uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .img_mode(img_mode),
    .frame_sync(frame_sync), .out_valid(out_valid), .out_addr(out_addr),
    .out_count(out_count), .frame_done(frame_done),
    .hit_overflow(hit_overflow), .seq_error(seq_error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    ser_in = b;
  endtask

  // idle gap: some ones, then at least two zeros (never forms 1,0,1)
  task automatic gap();
    int k1 = $urandom_range(0, 3);
    int k2 = $urandom_range(2, 4);
    for (int i = 0; i < k1; i++) send_bit(1'b1);
    for (int i = 0; i < k2; i++) send_bit(1'b0);
  endtask

  task automatic send_rec(input int cnt, input int addr);
    gap();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    for (int i = 4; i >= 0; i--) send_bit(cnt[i]);
    for (int i = 7; i >= 0; i--) send_bit(addr[i]);
    exp_cur[addr] = cnt;
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
  endtask

  task automatic do_sync(input string tag);
    settle();
    while (pending) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      exp_prev[i] = exp_cur[i];
      exp_cur[i] = 0;
    end
    cur_tag = tag;
    beat_idx = 0;
    frame_bad = 0;
    pending = 1'b1;
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (!pending || out_addr != beat_idx[7:0] || out_count != exp_prev[beat_idx & 255][4:0]) begin
          if (frame_bad == 0)
            $display("FAIL %s beat %0d actual addr=%0d count=%0d expected addr=%0d count=%0d",
                     cur_tag, beat_idx, out_addr, out_count, beat_idx, exp_prev[beat_idx & 255]);
          frame_bad++;
        end
        beat_idx++;
      end
      if (frame_done) begin
        check(frame_bad == 0 && beat_idx == 256, cur_tag, beat_idx, 256);
        pending = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin exp_cur[i] = 0; exp_prev[i] = 0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1 out_valid in reset", out_valid, 0);
    check(frame_done == 0, "R1 frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && frame_done == 0, "R1 outputs after reset", out_valid, 0);
    check(hit_overflow == 0 && seq_error == 0, "R1 flags after reset", hit_overflow, 0);

    // R4 empty frame: all zero (R2 idle noise only)
    for (int i = 0; i < 40; i++) gap();
    do_sync("R2/R4 empty frame");

    // random sparse frames; records overlap the previous drain (R7)
    for (int f = 0; f < 6; f++) begin
      int n = (f == 2) ? 62 : $urandom_range(1, 61);
      for (int r = 0; r < n; r++) send_rec($urandom_range(0, 31), $urandom_range(0, 255));
      settle();
      check(hit_overflow == 0, "R8 no overflow at <=62", hit_overflow, 0);
      do_sync("R4/R7 random sparse frame");
    end

    // R3: fields that contain 1,0,1; R6: duplicates, later wins
    send_rec(5'b10101, 8'b10110101);
    send_rec(3, 7);
    send_rec(30, 7);
    send_rec(31, 0);
    send_rec(17, 255);
    send_rec(9, 255);
    do_sync("R3/R6 directed duplicates");
    // R7: frame with a single record after a busy frame
    send_rec(12, 44);
    do_sync("R7 zero-fill after busy frame");

    // R8: overflow at 63rd record, record still stored
    for (int r = 0; r < 62; r++) send_rec($urandom_range(0, 31), r);
    settle();
    check(hit_overflow == 0, "R8 flag before 63rd", hit_overflow, 0);
    send_rec(21, 200);
    settle();
    check(hit_overflow == 1, "R8 flag after 63rd", hit_overflow, 1);
    send_rec(5, 201);
    settle();
    check(hit_overflow == 1, "R8 flag sticky", hit_overflow, 1);
    do_sync("R8 overflow frame contents");
    settle();
    check(hit_overflow == 0, "R8 flag cleared by sync", hit_overflow, 0);

    // R9/R10: imaging mode, ordered frame
    img_mode = 1'b1;
    for (int a = 0; a < 256; a++) send_rec($urandom_range(0, 31), a);
    settle();
    check(seq_error == 0, "R9 ordered imaging frame", seq_error, 0);
    check(hit_overflow == 0, "R10 no overflow in imaging", hit_overflow, 0);
    do_sync("R9 imaging frame contents");

    // R9: out-of-sequence address at index 100
    for (int a = 0; a < 100; a++) send_rec($urandom_range(0, 31), a);
    settle();
    check(seq_error == 0, "R9 before bad index", seq_error, 0);
    send_rec(19, 101);
    settle();
    check(seq_error == 1, "R9 bad index flagged", seq_error, 1);
    for (int a = 101; a < 256; a++) send_rec($urandom_range(0, 31), a);
    settle();
    check(seq_error == 1, "R9 flag sticky", seq_error, 1);
    do_sync("R9 frame with gap zero-filled");
    settle();
    check(seq_error == 0, "R9 flag cleared by sync", seq_error, 0);

    img_mode = 1'b0;
    do_sync("R7 empty frame after imaging");
    while (pending) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule